// File: doc/BRIEF.md
# DDR Mode Register Programming Sequencer

This block sits on the controller side of a DDR SDRAM command bus. It writes the base mode register or the extended mode register. When a request arrives, the block looks at the per-bank open flags. If any bank is open, it closes all banks with a precharge-all command and waits the row-precharge time. It then drives the mode register command, with the burst setup and the DLL-reset flag placed on the address bus.

After the mode register command, the block keeps the bus quiet for the mode-register-delay time. If the written word asks for a DLL reset, it also waits out the DLL lock period before it hands the bus back. The end of the sequence is marked by a one-cycle `done_o` pulse while `busy_o` falls. A request that arrives while a sequence is running waits in a single holding slot. A request that carries an unsupported burst-length code is refused.

Top module: `mr_prog_seq`

## Requirements
- R1: Out of reset, `cmd_o` is NOP (4'b0111), `addr_o` and `ba_o` are zero, and `busy_o`, `done_o` and `err_o` are low.
- R2: If any bit of `bank_open_i` is set when a request is accepted, a precharge command (4'b0010) with address bit A10 high and all other address bits zero appears in the cycle after acceptance. The mode register command follows exactly T_RP cycles after the precharge.
- R3: If no bank is open when a request is accepted, the mode register command (4'b0000) appears in the cycle after acceptance and no precharge is issued.
- R4: During the mode register command, A2:A0 carry the length code (001 = 2, 010 = 4, 011 = 8) and A3 carries the burst type (0 sequential, 1 interleave). A8 carries the DLL-reset flag and every other address bit is zero. `ba_o` is 00 for the base register and 01 for the extended register.
- R5: Without a DLL reset, `busy_o` falls and `done_o` pulses for one cycle exactly T_MRD cycles after the mode register command.
- R6: With a DLL reset, `busy_o` falls and `done_o` pulses exactly T_MRD + T_DLL cycles after the mode register command (defaults 2 + 200).
- R7: A request whose length code is not 001, 010 or 011 raises `err_o` for one cycle in the cycle after acceptance. No command is issued and `busy_o` stays low.
- R8: A request that arrives while busy is held and launches in the cycle after `done_o`. A further request that arrives while the slot is full is dropped.
- R9: `busy_o` is high from the first command of a sequence until `done_o`. Outside a precharge or mode register cycle, `cmd_o` is NOP, and it is always NOP while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Program request, sampled each cycle |
| ext_sel_i | input | 1 | 0 base mode register, 1 extended mode register |
| bl_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | Burst type, 1 interleave |
| dll_rst_i | input | 1 | Request DLL reset |
| bank_open_i | input | N_BANK | Per-bank open flags |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | One-cycle illegal-length pulse |
| cmd_o | output | 4 | {CS#, RAS#, CAS#, WE#} |
| addr_o | output | ADDR_W | Address bus |
| ba_o | output | BA_W | Bank address |

## Verification
The bench times each command against the cycle of acceptance. A precharge-to-mode gap that is off by one, or a precharge issued even though all banks are idle, shows up as an event in the wrong cycle. The DLL case checks that the long hold is added on top of the mode-register delay and not used in its place. Illegal length codes must produce an error pulse with no bus activity at all. A design that still issued the mode command here would produce an unexpected event. The holding-slot case sends a request while the block is busy and a second one behind it. A design that lost the first request, launched it early, or also accepted the overflow request would leave events missing, early or surplus.

// File: rtl/mr_seq_pkg.sv
package mr_seq_pkg;
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RP, ST_MRD, ST_DLL} st_e;

  typedef struct packed {
    logic       ext;
    logic [2:0] bl;
    logic       il;
    logic       dll;
  } mr_req_t;
endpackage

// File: rtl/mr_word_enc.sv
module mr_word_enc
  import mr_seq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int DLL_BIT = 8
) (
  input  mr_req_t           req_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              legal_o
);
  always_comb begin
    addr_o          = '0;
    addr_o[2:0]     = req_i.bl;
    addr_o[3]       = req_i.il;
    addr_o[DLL_BIT] = req_i.dll;
    ba_o            = '0;
    ba_o[0]         = req_i.ext;
    legal_o         = (req_i.bl == 3'b001) || (req_i.bl == 3'b010) || (req_i.bl == 3'b011);
  end
endmodule

// File: rtl/mr_timer.sv
module mr_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mr_req_hold.sv
module mr_req_hold
  import mr_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    set_i,
  input  mr_req_t data_i,
  input  logic    take_i,
  output logic    valid_o,
  output mr_req_t data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mr_prog_seq.sv
module mr_prog_seq
  import mr_seq_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int N_BANK   = 4,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_DLL    = 200,
  parameter int PALL_BIT = 10,
  parameter int DLL_BIT  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              ext_sel_i,
  input  logic [2:0]        bl_code_i,
  input  logic              interleave_i,
  input  logic              dll_rst_i,
  input  logic [N_BANK-1:0] bank_open_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);
  localparam int T_MAX = (T_DLL > T_RP) ? ((T_DLL > T_MRD) ? T_DLL : T_MRD)
                                        : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam int GAP_W = $clog2(T_RP + T_MRD + T_DLL + 2) + 1;

  st_e               state_q;
  cmd_e              cmd_q;
  logic [ADDR_W-1:0] word_addr_q;
  logic [BA_W-1:0]   word_ba_q;
  logic              dll_q;

  mr_req_t           in_req, pend_req, launch_req;
  logic              pend_valid, launch, hold_set, hold_take;
  logic [ADDR_W-1:0] enc_addr;
  logic [BA_W-1:0]   enc_ba;
  logic              enc_legal;
  logic              t_load, t_zero;
  logic [CNT_W-1:0]  t_val;

  assign in_req     = '{ext: ext_sel_i, bl: bl_code_i, il: interleave_i, dll: dll_rst_i};
  assign launch     = (state_q == ST_IDLE) && (pend_valid || req_i);
  assign launch_req = pend_valid ? pend_req : in_req;
  assign hold_take  = (state_q == ST_IDLE) && pend_valid;
  // idle with a held request: the held one launches, a new one refills the slot
  assign hold_set   = req_i && ((state_q != ST_IDLE) ? !pend_valid : pend_valid);

  mr_req_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hold_set),
    .data_i (in_req),
    .take_i (hold_take),
    .valid_o(pend_valid),
    .data_o (pend_req)
  );

  mr_word_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W), .DLL_BIT(DLL_BIT)) u_enc (
    .req_i  (launch_req),
    .addr_o (enc_addr),
    .ba_o   (enc_ba),
    .legal_o(enc_legal)
  );

  mr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(t_load),
    .val_i (t_val),
    .zero_o(t_zero)
  );

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (state_q)
      ST_IDLE: if (launch && enc_legal) begin
        t_load = 1'b1;
        t_val  = (|bank_open_i) ? CNT_W'(T_RP - 1) : CNT_W'(T_MRD - 1);
      end
      ST_RP:  if (t_zero) begin
        t_load = 1'b1;
        t_val  = CNT_W'(T_MRD - 1);
      end
      ST_MRD: if (t_zero && dll_q) begin
        t_load = 1'b1;
        t_val  = CNT_W'(T_DLL - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cmd_q       <= CMD_NOP;
      addr_o      <= '0;
      ba_o        <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      word_addr_q <= '0;
      word_ba_q   <= '0;
      dll_q       <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_o <= '0;
      ba_o   <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (launch) begin
          if (!enc_legal) begin
            err_o <= 1'b1;
          end else begin
            word_addr_q <= enc_addr;
            word_ba_q   <= enc_ba;
            dll_q       <= launch_req.dll;
            if (|bank_open_i) begin
              cmd_q            <= CMD_PRE;
              addr_o[PALL_BIT] <= 1'b1;
              state_q          <= ST_RP;
            end else begin
              cmd_q   <= CMD_MRS;
              addr_o  <= enc_addr;
              ba_o    <= enc_ba;
              state_q <= ST_MRD;
            end
          end
        end
        ST_RP: if (t_zero) begin
          cmd_q   <= CMD_MRS;
          addr_o  <= word_addr_q;
          ba_o    <= word_ba_q;
          state_q <= ST_MRD;
        end
        ST_MRD: if (t_zero) begin
          if (dll_q) state_q <= ST_DLL;
          else begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end
        end
        ST_DLL: if (t_zero) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_o  = cmd_q;
  assign busy_o = (state_q != ST_IDLE);

  // cycles since the last non-NOP command, for the timing assertions
  logic [GAP_W-1:0] gap_q;
  logic             last_pre_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= '1;
      last_pre_q <= 1'b0;
    end else if (cmd_o != CMD_NOP) begin
      gap_q      <= GAP_W'(1);
      last_pre_q <= (cmd_o == CMD_PRE);
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  p_pre_to_mrs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_MRS && last_pre_q) |-> gap_q == GAP_W'(T_RP));
  p_mrs_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_MRS) |-> (addr_o[2:0] inside {3'b001, 3'b010, 3'b011}) && ba_o[BA_W-1:1] == '0);
  p_mrd_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> gap_q >= GAP_W'(T_MRD));
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cmd_o == CMD_NOP) && !busy_o);
  p_idle_nop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cmd_o == CMD_NOP);
endmodule

// File: tb/mr_prog_seq_tb.sv
`timescale 1ns/1ps
module mr_prog_seq_tb;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int N_BANK = 4;
  localparam int T_RP   = 3;
  localparam int T_MRD  = 2;
  localparam int T_DLL  = 200;

  localparam int K_PRE  = 0;
  localparam int K_MRS  = 1;
  localparam int K_DONE = 2;
  localparam int K_ERR  = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, ext_sel_i = 1'b0, interleave_i = 1'b0, dll_rst_i = 1'b0;
  logic [2:0]        bl_code_i = '0;
  logic [N_BANK-1:0] bank_open_i = '0;
  logic              busy_o, done_o, err_o;
  logic [3:0]        cmd_o;
  logic [ADDR_W-1:0] addr_o;
  logic [BA_W-1:0]   ba_o;

  always #2.5 clk_i = ~clk_i;

  mr_prog_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .N_BANK(N_BANK),
                .T_RP(T_RP), .T_MRD(T_MRD), .T_DLL(T_DLL)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ext_sel_i(ext_sel_i),
    .bl_code_i(bl_code_i), .interleave_i(interleave_i), .dll_rst_i(dll_rst_i),
    .bank_open_i(bank_open_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .cmd_o(cmd_o), .addr_o(addr_o), .ba_o(ba_o)
  );

  typedef struct {
    int                kind;
    int                cyc;
    logic [ADDR_W-1:0] addr;
    logic [BA_W-1:0]   ba;
    logic              busy;
    string             tag;
  } ev_t;

  ev_t exp_q[$];
  int  cyc = 0, checks = 0, errors = 0, free_at = -10;

  always @(posedge clk_i) cyc++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic push(input int kind, input int c, input logic [ADDR_W-1:0] a,
                      input logic [BA_W-1:0] b, input logic bz, input string tag);
    ev_t e;
    e.kind = kind; e.cyc = c; e.addr = a; e.ba = b; e.busy = bz; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      int kind;
      kind = -1;
      if (cmd_o == 4'b0010) kind = K_PRE;
      else if (cmd_o == 4'b0000) kind = K_MRS;
      else if (cmd_o != 4'b0111) chk(0, "R9 cmd", cmd_o, 4'b0111);
      else if (done_o) kind = K_DONE;
      else if (err_o) kind = K_ERR;
      if (kind >= 0) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8/R9 unexpected event", kind, -1);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(kind == e.kind, {e.tag, " kind"}, kind, e.kind);
          chk(cyc == e.cyc, {e.tag, " cycle"}, cyc, e.cyc);
          chk(addr_o == e.addr, {e.tag, " addr"}, addr_o, e.addr);
          chk(ba_o == e.ba, {e.tag, " ba"}, ba_o, e.ba);
          chk(busy_o == e.busy, {e.tag, " busy"}, busy_o, e.busy);
        end
      end
    end
  end

  task automatic do_req(input bit ext, input bit [2:0] bl, input bit il, input bit dll,
                        input bit open, input bit drop, input string tag);
    int n, l, m, d;
    logic [ADDR_W-1:0] w;
    n = cyc;
    l = (n + 1 > free_at + 1) ? n + 1 : free_at + 1;
    w = '0; w[2:0] = bl; w[3] = il; w[8] = dll;
    if (!drop) begin
      if (!(bl inside {3'b001, 3'b010, 3'b011})) begin
        push(K_ERR, l, '0, '0, 1'b0, "R7");
      end else begin
        if (open) begin
          push(K_PRE, l, ADDR_W'(1) << 10, '0, 1'b1, {"R2 ", tag});
          m = l + T_RP;
        end else m = l;
        push(K_MRS, m, w, {1'b0, ext}, 1'b1, {"R4 ", tag});
        d = m + T_MRD + (dll ? T_DLL : 0);
        push(K_DONE, d, '0, '0, 1'b0, dll ? {"R6 ", tag} : {"R5 ", tag});
        free_at = d;
      end
    end
    bank_open_i = open ? 4'b0100 : 4'b0000;
    ext_sel_i = ext; bl_code_i = bl; interleave_i = il; dll_rst_i = dll;
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (cyc < free_at + 3) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(cmd_o == 4'b0111, "R1 cmd in reset", cmd_o, 4'b0111);
    chk(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
    chk(done_o == 1'b0 && err_o == 1'b0, "R1 done/err in reset", {done_o, err_o}, 0);
    chk(addr_o == '0 && ba_o == '0, "R1 addr/ba in reset", addr_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cmd_o == 4'b0111 && !busy_o, "R1 after release", cmd_o, 4'b0111);

    // R2 R4 R5: base register, length 4 sequential, bank open
    do_req(1'b0, 3'b010, 1'b0, 1'b0, 1'b1, 1'b0, "bl4 seq");
    wait_idle();
    // R3 R4: extended register, length 8 interleave, banks idle
    do_req(1'b1, 3'b011, 1'b1, 1'b0, 1'b0, 1'b0, "R3 emrs direct");
    wait_idle();
    // R6: DLL reset adds the lock hold
    do_req(1'b0, 3'b001, 1'b0, 1'b1, 1'b1, 1'b0, "dll");
    wait_idle();
    // R7: illegal codes
    do_req(1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, "bad0");
    chk(busy_o == 1'b0, "R7 busy after bad code", busy_o, 0);
    do_req(1'b1, 3'b101, 1'b1, 1'b0, 1'b0, 1'b0, "bad5");
    chk(busy_o == 1'b0, "R7 busy after bad code", busy_o, 0);
    wait_idle();
    // R8: held request, overflow dropped
    do_req(1'b0, 3'b010, 1'b1, 1'b0, 1'b1, 1'b0, "first");
    @(negedge clk_i);
    chk(busy_o == 1'b1, "R9 busy mid-sequence", busy_o, 1);
    do_req(1'b1, 3'b011, 1'b0, 1'b0, 1'b1, 1'b0, "R8 held");
    do_req(1'b0, 3'b001, 1'b0, 1'b0, 1'b1, 1'b1, "R8 dropped");
    wait_idle();
    repeat (5) @(negedge clk_i);
    chk(exp_q.size() == 0, "R8 missing events", exp_q.size(), 0);
    chk(busy_o == 1'b0 && cmd_o == 4'b0111, "R9 idle at end", cmd_o, 4'b0111);
    finish_run();
  end
endmodule